// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block turns bytes written by a processor into an asynchronous serial stream on one line. Each byte goes first into an eight-entry queue. A framing stage takes bytes from the queue and sends each one as a start bit, five to eight data bits, an optional parity bit and one or two stop bits. A bit lasts sixteen pulses of an external bit-rate enable.

Software controls the block through a small command port. The commands enable the transmitter, disable it, reset it, and start or end a break. Two status outputs, ready and empty, follow exact set and clear rules. The ready output is copied to an interrupt request.

A disable lets queued data drain, but a reset drops it at once. When the handshake option is on, the active-low clear-to-send input is looked at only when a new character is about to start.

Top module: `sertx_core`

## Requirements
- R1: A character is sent on `txd` as a low start bit, then the data bits starting with the least significant one, then the parity bit if one is selected, then high stop bits. Every bit lasts 16 cycles in which `tick16_en` is high. `cfg_len` selects the data length as 5 + `cfg_len` bits (0 gives 5, 3 gives 8). Unused upper data bits are dropped.
- R2: `cfg_par` selects parity: 0 means no parity bit. 1 means even (the parity bit makes the count of ones in data plus parity even). 2 means odd. 3 means the parity bit is always 1.
- R3: `cfg_two_stop` = 0 sends one stop bit and 1 sends two.
- R4: `tx_rdy` is 1 exactly when the transmitter is enabled and the queue is not full. `tx_irq` always equals `tx_rdy`.
- R5: The enable command (`cmd` = 1) sets `tx_rdy` and `tx_emt` on the next edge. An accepted write clears `tx_emt` on the next edge.
- R6: `tx_emt` becomes 1 on the edge that ends the last stop bit, if the queue is empty and the transmitter is enabled. While a character is still queued it stays 0.
- R7: The queue holds 8 characters and sends them in write order. A write while the queue is full is ignored and never sent.
- R8: The disable command (`cmd` = 2) clears `tx_rdy` and `tx_emt` on the next edge. The character in progress and all queued characters are still sent. Writes while disabled are ignored, and `tx_emt` stays 0 after the drain.
- R9: The reset command (`cmd` = 3) returns `txd` high on the next edge, aborting any character in progress. It also empties the queue, clears `tx_rdy`, `tx_emt` and break, and leaves the transmitter disabled until the next enable command.
- R10: The break-on command (`cmd` = 4) drives `txd` low from the next edge until the break-off command (`cmd` = 5), which returns it to the level of the framing stage (high when idle).
- R11: With `cts_mode` = 1, a queued character starts only while `cts_n` is 0. A change of `cts_n` after a character has started does not affect that character.
- R12: When no character is being sent and break is off, `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_en | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for a character |
| wr_data | input | DATA_W | Character to queue |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code: 1 enable, 2 disable, 3 reset, 4 break on, 5 break off; others ignored |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced one |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cts_mode | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output, idle high |
| tx_rdy | output | 1 | Queue can accept a character |
| tx_emt | output | 1 | Transmitter has gone fully empty |
| tx_irq | output | 1 | Interrupt request, equal to tx_rdy |

## Verification
A write is accepted on the first edge after it is driven, so `tx_emt` is checked at the following falling edge. The start bit begins one edge later. The bench finds that falling level at a falling clock edge, then samples 7 cycles later and every 16 cycles after that. Every sample therefore lands near the middle of a bit, with `tick16_en` held high. Commands take effect on the first edge after they are driven and are checked at the next falling edge. The empty flag is checked 12 cycles after the middle of the last stop bit, which is past the edge that ends that bit. Checks that something never happens watch `txd` for several hundred cycles.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ENABLE  = 3'd1,
    CMD_DISABLE = 3'd2,
    CMD_RESET   = 3'd3,
    CMD_BRK_ON  = 3'd4,
    CMD_BRK_OFF = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ONE  = 2'd3
  } par_e;

endpackage

// File: rtl/sertx_fifo.sv
`timescale 1ns/1ps
// Character queue; DEPTH must be a power of two, at least 2.
module sertx_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = mem[rp_q];
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + AW'(1);
      if (do_pop)  rp_n = rp_q + AW'(1);
      cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
// Builds the complete bit sequence of one character, first bit at index 0.
module sertx_framer import sertx_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         len_sel,
  input  par_e               par_mode,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  localparam int MIN_LEN = DATA_W - 3;

  logic [CNT_W-1:0]   dlen;
  logic [DATA_W-1:0]  kept;
  logic [FRAME_W-1:0] body, upper;
  logic               pbit;

  always_comb begin
    dlen  = CNT_W'(MIN_LEN) + CNT_W'(len_sel);
    kept  = data & ~({DATA_W{1'b1}} << dlen);
    body  = {{(FRAME_W-DATA_W-1){1'b0}}, kept, 1'b0};
    upper = {FRAME_W{1'b1}} << (dlen + CNT_W'(1));
    unique case (par_mode)
      PAR_EVEN: pbit = ^kept;
      PAR_ODD:  pbit = ~^kept;
      default:  pbit = 1'b1;
    endcase
    frame = body | upper;
    if (par_mode != PAR_NONE)
      frame = frame & ~(FRAME_W'(!pbit) << (dlen + CNT_W'(1)));
    nbits = dlen + CNT_W'(par_mode != PAR_NONE)
          + (two_stop ? CNT_W'(3) : CNT_W'(2));
  end

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
module sertx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 4,
  parameter int TPB     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               tick,
  output logic               busy,
  output logic               done,
  output logic               sout
);
  localparam int TW = (TPB > 1) ? $clog2(TPB) : 1;

  logic               busy_q, busy_n;
  logic [FRAME_W-1:0] sreg_q, sreg_n;
  logic [CNT_W-1:0]   bitc_q, bitc_n;
  logic [TW-1:0]      tcnt_q, tcnt_n;

  always_comb begin
    busy_n = busy_q;
    sreg_n = sreg_q;
    bitc_n = bitc_q;
    tcnt_n = tcnt_q;
    done   = 1'b0;
    if (abort) begin
      busy_n = 1'b0;
    end else if (!busy_q && load) begin
      busy_n = 1'b1;
      sreg_n = frame;
      bitc_n = nbits - CNT_W'(1);
      tcnt_n = '0;
    end else if (busy_q && tick) begin
      if (tcnt_q == TW'(TPB - 1)) begin
        tcnt_n = '0;
        if (bitc_q == '0) begin
          busy_n = 1'b0;
          done   = 1'b1;
        end else begin
          sreg_n = {1'b1, sreg_q[FRAME_W-1:1]};
          bitc_n = bitc_q - CNT_W'(1);
        end
      end else begin
        tcnt_n = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sreg_q <= '1;
      bitc_q <= '0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_n;
      sreg_q <= sreg_n;
      bitc_q <= bitc_n;
      tcnt_q <= tcnt_n;
    end
  end

  assign busy = busy_q;
  assign sout = busy_q ? sreg_q[0] : 1'b1;

endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core import sertx_pkg::*; #(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic              cts_mode,
  input  logic              cts_n,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_emt,
  output logic              tx_irq
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int FCW     = $clog2(FIFO_DEPTH) + 1;

  logic en_q, en_n, emt_q, emt_n, brk_q, brk_n;
  logic is_en, is_dis, is_rst, is_bon, is_boff;
  logic push, pop, fifo_full, fifo_empty, ser_busy, ser_done, ser_out, cts_ok;
  logic [DATA_W-1:0]  head;
  logic [FCW-1:0]     fifo_cnt;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign is_en   = cmd_valid && (cmd == CMD_ENABLE);
  assign is_dis  = cmd_valid && (cmd == CMD_DISABLE);
  assign is_rst  = cmd_valid && (cmd == CMD_RESET);
  assign is_bon  = cmd_valid && (cmd == CMD_BRK_ON);
  assign is_boff = cmd_valid && (cmd == CMD_BRK_OFF);

  assign push   = wr_en && en_q && !fifo_full;
  assign cts_ok = !cts_mode || !cts_n;
  assign pop    = !ser_busy && !fifo_empty && cts_ok && !is_rst;

  sertx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(is_rst), .push(push), .wdata(wr_data),
    .pop(pop), .rdata(head), .full(fifo_full), .empty(fifo_empty),
    .count(fifo_cnt)
  );

  sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) framer_i (
    .data(head), .len_sel(cfg_len), .par_mode(par_e'(cfg_par)),
    .two_stop(cfg_two_stop), .frame(frame), .nbits(nbits)
  );

  sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .TPB(TICKS_PER_BIT)) shift_i (
    .clk(clk), .rst_n(rst_n), .abort(is_rst), .load(pop), .frame(frame),
    .nbits(nbits), .tick(tick16_en), .busy(ser_busy), .done(ser_done),
    .sout(ser_out)
  );

  always_comb begin
    en_n  = en_q;
    emt_n = emt_q;
    brk_n = brk_q;
    if (is_en) en_n = 1'b1;
    if (is_dis || is_rst) en_n = 1'b0;
    if (is_rst || is_dis)            emt_n = 1'b0;
    else if (is_en)                  emt_n = 1'b1;
    else if (push)                   emt_n = 1'b0;
    else if (ser_done && fifo_empty && en_q) emt_n = 1'b1;
    if (is_rst || is_boff) brk_n = 1'b0;
    else if (is_bon)       brk_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      emt_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      emt_q <= emt_n;
      brk_q <= brk_n;
    end
  end

  assign txd    = brk_q ? 1'b0 : ser_out;
  assign tx_rdy = en_q && !fifo_full;
  assign tx_emt = emt_q;
  assign tx_irq = tx_rdy;

endmodule

// File: rtl/sertx_core_chk.sv
`timescale 1ns/1ps
module sertx_core_chk import sertx_pkg::*; #(
  parameter int FIFO_DEPTH = 8,
  localparam int FCW = $clog2(FIFO_DEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           cmd_valid,
  input logic [2:0]     cmd,
  input logic           cts_mode,
  input logic           cts_n,
  input logic           txd,
  input logic           tx_rdy,
  input logic           tx_emt,
  input logic           busy,
  input logic [FCW-1:0] fifo_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= FCW'(FIFO_DEPTH)); // R7
  AST_FULL_NOT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == FCW'(FIFO_DEPTH)) |-> !tx_rdy); // R4
  AST_WRITE_CLR_EMT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_rdy && !cmd_valid) |=> !tx_emt); // R5
  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_DISABLE) |=> (!tx_rdy && !tx_emt)); // R8
  AST_RESET_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_RESET) |=> (txd && !busy && fifo_cnt == '0 && !tx_rdy && !tx_emt)); // R9
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_BRK_ON) |=> !txd); // R10
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_mode && cts_n && !busy) |=> !busy); // R11
endmodule

bind sertx_core sertx_core_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_valid(cmd_valid), .cmd(cmd),
  .cts_mode(cts_mode), .cts_n(cts_n), .txd(txd), .tx_rdy(tx_rdy),
  .tx_emt(tx_emt), .busy(ser_busy), .fifo_cnt(fifo_cnt)
);

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16_en = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic cfg_two_stop = 1'b0;
  logic cts_mode = 1'b0;
  logic cts_n = 1'b0;
  logic txd, tx_rdy, tx_emt, tx_irq;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sertx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick16_en(tick16_en), .wr_en(wr_en),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd(cmd), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .cts_mode(cts_mode),
    .cts_n(cts_n), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic do_cmd(input logic [2:0] c);
    cmd_valid = 1'b1;
    cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd = '0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Waits for a start bit and samples nb bits near their middles.
  task automatic capture(input int nb, input bit drop_cts, output logic [11:0] bits);
    int waitc;
    waitc = 0;
    bits = '0;
    while (txd !== 1'b0 && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    if (waitc >= 3000) begin
      bits = '1;
    end else begin
      repeat (7) @(negedge clk);
      bits[0] = txd;
      if (drop_cts) cts_n = 1'b1;
      for (int i = 1; i < nb; i++) begin
        repeat (16) @(negedge clk);
        bits[i] = txd;
      end
    end
  endtask

  task automatic expect_level(input int n, input logic lvl, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== lvl) bad++;
    end
    check(req, bad, 0);
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input int ln,
                                            input int pm, input int st, output int nb);
    int dl, m, ones, pbit, idx, v;
    dl = 5 + ln;
    m = int'(d) % (1 << dl);
    ones = $countones(m);
    pbit = (pm == 1) ? ones % 2 : (pm == 2) ? 1 - (ones % 2) : 1;
    v = m * 2;
    idx = 1 + dl;
    if (pm != 0) begin
      v = v + pbit * (1 << idx);
      idx++;
    end
    for (int s = 0; s <= st; s++) v = v + (1 << (idx + s));
    nb = idx + 1 + st;
    return v[11:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] got, exp;
    logic [7:0] vals [9];
    int nb, nb8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R12 idle txd after reset", txd, 1);
    check("R4 rdy after reset", tx_rdy, 0);
    check("R4 irq after reset", tx_irq, 0);
    check("R5 emt after reset", tx_emt, 0);

    do_cmd(3'd1);
    check("R5 rdy on enable", tx_rdy, 1);
    check("R5 emt on enable", tx_emt, 1);
    check("R4 irq equals rdy", tx_irq, 1);

    // sweep every length, parity and stop setting
    for (int ln = 0; ln < 4; ln++)
      for (int pm = 0; pm < 4; pm++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 2; k++) begin
            logic [7:0] d;
            d = 8'((ln * 37 + pm * 11 + st * 91 + k * 90 + 5) % 256);
            cfg_len = 2'(ln);
            cfg_par = 2'(pm);
            cfg_two_stop = 1'(st);
            exp = exp_frame(d, ln, pm, st, nb);
            do_wr(d);
            check("R5 write clears emt", tx_emt, 0);
            capture(nb, 1'b0, got);
            check($sformatf("R1 R2 R3 frame len%0d par%0d stop%0d", ln, pm, st), got, exp);
            repeat (12) @(negedge clk);
            check("R6 emt after last stop", tx_emt, 1);
            check("R12 idle high after frame", txd, 1);
          end

    // queue depth and clear-to-send hold
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_two_stop = 1'b0;
    cts_mode = 1'b1; cts_n = 1'b1;
    for (int i = 0; i < 9; i++) begin
      vals[i] = 8'((16 + i * 29) % 256);
      do_wr(vals[i]);
      if (i == 7) begin
        check("R4 rdy low when full", tx_rdy, 0);
        check("R4 irq low when full", tx_irq, 0);
      end
    end
    check("R6 emt low while queued", tx_emt, 0);
    expect_level(100, 1'b1, "R11 held while cts_n high");
    cts_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      capture(10, 1'b0, got);
      check($sformatf("R7 order item %0d", i), {22'd0, got[9:0]}, {22'd0, 1'b1, vals[i], 1'b0});
    end
    expect_level(300, 1'b1, "R7 write to full queue dropped");
    check("R6 emt after drain", tx_emt, 1);

    // clear-to-send raised mid-character
    do_wr(8'hC3);
    do_wr(8'h5A);
    capture(10, 1'b1, got);
    check("R11 started char unaffected", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'hC3, 1'b0});
    expect_level(200, 1'b1, "R11 next char waits");
    cts_n = 1'b0;
    capture(10, 1'b0, got);
    check("R11 char after cts low", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h5A, 1'b0});
    cts_mode = 1'b0;
    repeat (20) @(negedge clk);

    // disable drains the queue
    do_wr(8'h81);
    do_wr(8'h42);
    do_wr(8'h24);
    do_cmd(3'd2);
    check("R8 rdy cleared by disable", tx_rdy, 0);
    check("R8 emt cleared by disable", tx_emt, 0);
    do_wr(8'hFF);
    capture(10, 1'b0, got);
    check("R8 drain 1", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h81, 1'b0});
    capture(10, 1'b0, got);
    check("R8 drain 2", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h42, 1'b0});
    capture(10, 1'b0, got);
    check("R8 drain 3", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h24, 1'b0});
    expect_level(300, 1'b1, "R8 write while disabled dropped");
    check("R8 emt stays low", tx_emt, 0);

    // reset aborts and flushes
    do_cmd(3'd1);
    do_wr(8'h99);
    do_wr(8'h66);
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    do_cmd(3'd3);
    check("R9 txd high after reset", txd, 1);
    check("R9 rdy cleared", tx_rdy, 0);
    check("R9 emt cleared", tx_emt, 0);
    do_wr(8'h11);
    expect_level(400, 1'b1, "R9 nothing sent after reset");
    do_cmd(3'd1);
    check("R9 rdy after re-enable", tx_rdy, 1);
    do_wr(8'h3E);
    capture(10, 1'b0, got);
    check("R9 queue flushed", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h3E, 1'b0});
    repeat (12) @(negedge clk);

    // break
    do_cmd(3'd4);
    expect_level(80, 1'b0, "R10 break holds low");
    do_cmd(3'd5);
    check("R10 break off returns high", txd, 1);
    expect_level(20, 1'b1, "R12 idle after break");

    nb8 = 0;
    finish_run();
  end
endmodule